// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM's contents alive. A programmable interval timer counts bus clocks and, when an interval has elapsed, raises an auto-refresh request towards the memory command arbiter. When the arbiter grants the request, the block issues a refresh command for one clock and reloads the timer. It then holds an activate-inhibit flag for a programmable recovery time, during which no row may be opened.

A level-controlled software bit moves the memory into and out of self-refresh. When the bit is set and the blocking mode flag is clear, the block waits for any refresh in flight and its recovery window to finish. It then requests and issues a self-refresh entry command. The interval timer is frozen while the memory refreshes itself. When the bit is cleared, the block requests and issues the exit command. It then inhibits activations for the longest recovery time and restarts the interval timer from a fresh load. Every command goes through a request/grant handshake with the arbiter. A busy flag tells the rest of the controller that refresh activity is under way.

Top module: `sdram_refresh_seq`

## Requirements
- R1: A synchronous reset leaves the block idle with the memory awake. After reset, `arb_req` and `act_inhibit` are 0, `mem_cmd` is NOP (2'b00) and `rfsh_busy` is 0.
- R2: A refresh request (`arb_req`=1, `arb_cmd`=REF 2'b01) appears (RC+1)*16 clock edges after the edge that loaded the timer. That edge is the last reset edge or a refresh/exit grant edge. RC is the 9-bit `cfg_rc`.
- R3: A raised refresh request, together with `rfsh_busy`, stays asserted and unchanged until it is granted. No command is issued while it waits.
- R4: A grant is taken at a rising edge where `arb_req` and `arb_gnt` are both 1. In the following clock only, `mem_cmd` carries the granted code. In that same clock `arb_req` is low.
- R5: After a refresh grant, `act_inhibit` is high for exactly 3, 6 or 9 clocks for `cfg_rtsel` = 2'b00, 2'b01 or 2'b1x. The inhibit starts in the clock that carries the refresh command.
- R6: A self-refresh entry command (SELF 2'b10) is requested and issued only while `cfg_selfreq`=1 and `cfg_selfblock`=0. With `cfg_selfblock`=1, only refresh requests appear.
- R7: Entry waits for any pending refresh to be granted and for its recovery window to end. The SELF request appears one clock after `act_inhibit` falls, and never while it is high.
- R8: While the memory is in self-refresh, no request and no command appear and `rfsh_busy` stays 1. The interval timer holds its count.
- R9: Clearing `cfg_selfreq` in self-refresh raises an exit request (SELFX 2'b11) in the next clock. After its grant, `act_inhibit` is high for exactly 9 clocks.
- R10: After an exit grant, the next refresh request follows a full fresh interval of (RC+1)*16 clocks. The frozen count is not resumed.
- R11: A change of `cfg_rc` does not alter the interval in progress. The new value is used from the next timer load on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rc | input | 9 | Refresh interval in units of 16 clocks, minus one |
| cfg_rtsel | input | 2 | Recovery select: 00=3, 01=6, 1x=9 clocks |
| cfg_selfreq | input | 1 | Self-refresh request level |
| cfg_selfblock | input | 1 | Mode flag that prevents self-refresh entry |
| arb_gnt | input | 1 | Arbiter grant for the current request |
| arb_req | output | 1 | Command request to the arbiter |
| arb_cmd | output | 2 | Code of the requested command (NOP when idle) |
| mem_cmd | output | 2 | Command issued this clock, one clock per grant |
| act_inhibit | output | 1 | Row activations forbidden |
| rfsh_busy | output | 1 | Refresh pending, recovering or self-refresh episode active |

## Verification
The bench measures each interval edge by edge from the grant, so a timer that is off by one prescaler step or one reload shows up as a wrong count. It tries every recovery select and counts inhibit clocks. A counter that loads one late or stops one early misses by one. The bench asks for self-refresh while a refresh is pending. A design that skips the pending refresh, or enters during recovery, requests SELF early or with the inhibit high. It stays asleep for several intervals, then checks that the first refresh after exit comes a full interval later. A design that resumes the frozen count fires early.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_REF   = 2'b01,
    CMD_SELF  = 2'b10,
    CMD_SELFX = 2'b11
  } mem_cmd_e;

  typedef enum logic [1:0] {
    ST_AWAKE,
    ST_ENTER,
    ST_ASLEEP,
    ST_EXIT
  } sr_state_e;

  localparam int REC_W = 4;

  // recovery window in clocks for a given select code
  function automatic logic [REC_W-1:0] recovery_clocks(input logic [1:0] sel);
    case (sel)
      2'b00:   recovery_clocks = REC_W'(3);
      2'b01:   recovery_clocks = REC_W'(6);
      default: recovery_clocks = REC_W'(9);
    endcase
  endfunction

  // longest window, used after leaving self-refresh
  function automatic logic [REC_W-1:0] recovery_max();
    recovery_max = recovery_clocks(2'b10);
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int RC_W  = 9,
  parameter int PRE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            reload,
  input  logic [RC_W-1:0] rc,
  output logic            expire
);

  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q;
  logic [RC_W-1:0]  cnt_q;
  logic             step;

  assign step   = run && (pre_q == PRE_LAST);
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      pre_q <= '0;
      cnt_q <= rc;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
      if (step) begin
        if (cnt_q == '0) cnt_q <= rc;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !reload) |=> ($stable(pre_q) && $stable(cnt_q))); // R8

endmodule

// File: rtl/rfsh_recovery.sv
module rfsh_recovery #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             hold
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= len;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold = (cnt_q != '0);

  AST_REC_START: assert property (@(posedge clk) disable iff (rst)
    (load && len != '0) |=> hold); // R5
  AST_REC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!load && !hold) |=> !hold); // R5

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_rfsh_pkg::*;
#(
  parameter int RC_W  = 9,
  parameter int PRE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RC_W-1:0] cfg_rc,
  input  logic [1:0]      cfg_rtsel,
  input  logic            cfg_selfreq,
  input  logic            cfg_selfblock,
  input  logic            arb_gnt,
  output logic            arb_req,
  output logic [1:0]      arb_cmd,
  output logic [1:0]      mem_cmd,
  output logic            act_inhibit,
  output logic            rfsh_busy
);

  sr_state_e        state_q, state_d;
  logic             ref_pend_q;
  mem_cmd_e         cmd_q;
  mem_cmd_e         req_code;
  logic             want_self;
  logic             tmr_expire;
  logic             tmr_run;
  logic             tmr_reload;
  logic             rec_load;
  logic [REC_W-1:0] rec_len;

  // named events
  logic ev_ref_grant, ev_self_grant, ev_exit_grant;

  assign want_self     = cfg_selfreq && !cfg_selfblock;
  assign ev_ref_grant  = (state_q == ST_AWAKE) && ref_pend_q && arb_gnt;
  assign ev_self_grant = (state_q == ST_ENTER) && want_self && arb_gnt;
  assign ev_exit_grant = (state_q == ST_EXIT) && !cfg_selfreq && arb_gnt;

  // request towards the arbiter
  always_comb begin
    req_code = CMD_NOP;
    unique case (state_q)
      ST_AWAKE:  if (ref_pend_q)   req_code = CMD_REF;
      ST_ENTER:  if (want_self)    req_code = CMD_SELF;
      ST_EXIT:   if (!cfg_selfreq) req_code = CMD_SELFX;
      default:   req_code = CMD_NOP;
    endcase
  end

  assign arb_req = (req_code != CMD_NOP);
  assign arb_cmd = req_code;

  // self-refresh state machine
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:
        if (want_self && !ref_pend_q && !act_inhibit && !tmr_expire)
          state_d = ST_ENTER;
      ST_ENTER:
        if (ev_self_grant)   state_d = ST_ASLEEP;
        else if (!want_self) state_d = ST_AWAKE;
      ST_ASLEEP:
        if (!cfg_selfreq)    state_d = ST_EXIT;
      ST_EXIT:
        if (ev_exit_grant)   state_d = ST_AWAKE;
        else if (cfg_selfreq) state_d = ST_ASLEEP;
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_AWAKE;
      ref_pend_q <= 1'b0;
      cmd_q      <= CMD_NOP;
    end else begin
      state_q <= state_d;
      if (ev_ref_grant)    ref_pend_q <= 1'b0;
      else if (tmr_expire) ref_pend_q <= 1'b1;
      if (ev_ref_grant)       cmd_q <= CMD_REF;
      else if (ev_self_grant) cmd_q <= CMD_SELF;
      else if (ev_exit_grant) cmd_q <= CMD_SELFX;
      else                    cmd_q <= CMD_NOP;
    end
  end

  assign mem_cmd = cmd_q;

  // timer and recovery control
  assign tmr_run    = (state_q == ST_AWAKE);
  assign tmr_reload = ev_ref_grant || ev_exit_grant;
  assign rec_load   = ev_ref_grant || ev_exit_grant;
  assign rec_len    = ev_exit_grant ? recovery_max() : recovery_clocks(cfg_rtsel);

  rfsh_interval_timer #(
    .RC_W  (RC_W),
    .PRE_W (PRE_W)
  ) i_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (tmr_run),
    .reload (tmr_reload),
    .rc     (cfg_rc),
    .expire (tmr_expire)
  );

  rfsh_recovery #(
    .CNT_W (REC_W)
  ) i_recovery (
    .clk  (clk),
    .rst  (rst),
    .load (rec_load),
    .len  (rec_len),
    .hold (act_inhibit)
  );

  assign rfsh_busy = ref_pend_q || act_inhibit || (state_q != ST_AWAKE);

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ref_pend_q && !ev_ref_grant) |=> ref_pend_q); // R3
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (arb_req && arb_gnt) |=> !arb_req); // R4
  AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd != CMD_NOP) |-> $past(arb_req && arb_gnt)); // R4
  AST_INH_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(act_inhibit) |-> (mem_cmd == CMD_REF || mem_cmd == CMD_SELFX)); // R5
  AST_SELF_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == CMD_SELF) |-> $past(cfg_selfreq && !cfg_selfblock)); // R6
  AST_SELF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (arb_req && arb_cmd == CMD_SELF) |-> !act_inhibit); // R7
  AST_NO_REF_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ASLEEP) |-> (!ref_pend_q && !arb_req)); // R8

endmodule

// File: tb/test_sdram_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_refresh_seq;

  localparam int C_NOP = 0, C_REF = 1, C_SELF = 2, C_SELFX = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] cfg_rc = 9'd2;
  logic [1:0] cfg_rtsel = 2'b00;
  logic       cfg_selfreq = 1'b0;
  logic       cfg_selfblock = 1'b0;
  logic       arb_gnt = 1'b0;
  logic       arb_req;
  logic [1:0] arb_cmd;
  logic [1:0] mem_cmd;
  logic       act_inhibit;
  logic       rfsh_busy;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  sdram_refresh_seq i_sdram_refresh_seq (
    .clk           (clk),
    .rst           (rst),
    .cfg_rc        (cfg_rc),
    .cfg_rtsel     (cfg_rtsel),
    .cfg_selfreq   (cfg_selfreq),
    .cfg_selfblock (cfg_selfblock),
    .arb_gnt       (arb_gnt),
    .arb_req       (arb_req),
    .arb_cmd       (arb_cmd),
    .mem_cmd       (mem_cmd),
    .act_inhibit   (act_inhibit),
    .rfsh_busy     (rfsh_busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // expected interval in clocks, from the requirement wording
  function automatic int interval_of(input int rc);
    return 16 * (rc + 1);
  endfunction

  // grant the pending request, then count inhibit clocks and the gap to the next request
  task automatic grant_measure(input string tag, input int code, input int inh_exp,
                               input int next_exp, input logic [8:0] rc_after);
    int inh = 0;
    int n = 0;
    arb_gnt = 1'b1;
    tick();
    arb_gnt = 1'b0;
    cfg_rc  = rc_after;
    chk(tag, "issued command", int'(mem_cmd), code);
    chk(tag, "request dropped after grant", int'(arb_req), 0);
    if (act_inhibit) inh++;
    while (!arb_req && n < 20000) begin
      tick();
      n++;
      if (n == 1) chk(tag, "command lasts one clock", int'(mem_cmd), C_NOP);
      if (act_inhibit) inh++;
    end
    chk(tag, "inhibit clocks", inh, inh_exp);
    chk(tag, "clocks to next refresh request", n, next_exp);
    chk(tag, "next request code", int'(arb_cmd), C_REF);
  endtask

  task automatic t_reset();
    int n = 0;
    rst = 1'b1;
    repeat (3) tick();
    chk("R1", "arb_req in reset", int'(arb_req), 0);
    chk("R1", "mem_cmd in reset", int'(mem_cmd), C_NOP);
    chk("R1", "inhibit in reset", int'(act_inhibit), 0);
    chk("R1", "busy in reset", int'(rfsh_busy), 0);
    rst = 1'b0;
    while (!arb_req && n < 20000) begin
      tick();
      n++;
    end
    chk("R2", "first interval after reset", n, interval_of(2));
  endtask

  task automatic t_hold();
    int bad = 0;
    repeat (20) begin
      tick();
      if (!arb_req || int'(arb_cmd) != C_REF || int'(mem_cmd) != C_NOP || !rfsh_busy) bad++;
    end
    chk("R3", "clocks with request not held", bad, 0);
    grant_measure("R4/R5/R2", C_REF, 3, interval_of(2), 9'd2);
  endtask

  task automatic t_recovery();
    cfg_rtsel = 2'b01;
    grant_measure("R5 sel01", C_REF, 6, interval_of(2), 9'd2);
    cfg_rtsel = 2'b11;
    grant_measure("R5 sel11", C_REF, 9, interval_of(2), 9'd2);
    cfg_rtsel = 2'b00;
  endtask

  task automatic t_rc_change();
    grant_measure("R11 old value kept", C_REF, 3, interval_of(2), 9'd0);
    grant_measure("R11 new value used", C_REF, 3, interval_of(0), 9'd0);
    grant_measure("R11 back", C_REF, 3, interval_of(0), 9'd2);
  endtask

  task automatic t_blocked();
    cfg_selfreq   = 1'b1;
    cfg_selfblock = 1'b1;
    grant_measure("R6 blocked", C_REF, 3, interval_of(2), 9'd2);
  endtask

  task automatic t_enter();
    int n = 0;
    cfg_selfblock = 1'b0;
    repeat (4) tick();
    chk("R7", "pending refresh served first", int'(arb_cmd), C_REF);
    arb_gnt = 1'b1;
    tick();
    arb_gnt = 1'b0;
    chk("R7", "refresh issued before entry", int'(mem_cmd), C_REF);
    while (!arb_req && n < 200) begin
      tick();
      n++;
    end
    chk("R7", "clocks from grant to SELF request", n, 3 + 1);
    chk("R7", "request code", int'(arb_cmd), C_SELF);
    chk("R7", "inhibit at SELF request", int'(act_inhibit), 0);
    arb_gnt = 1'b1;
    tick();
    arb_gnt = 1'b0;
    chk("R6", "entry command", int'(mem_cmd), C_SELF);
    chk("R6", "request dropped after entry", int'(arb_req), 0);
  endtask

  task automatic t_asleep();
    int act = 0;
    int idle = 0;
    repeat (150) begin
      tick();
      if (arb_req || int'(mem_cmd) != C_NOP) act++;
      if (!rfsh_busy) idle++;
    end
    chk("R8", "requests or commands while asleep", act, 0);
    chk("R8", "clocks with busy low while asleep", idle, 0);
  endtask

  task automatic t_exit();
    cfg_selfreq = 1'b0;
    tick();
    chk("R9", "exit request raised", int'(arb_req), 1);
    chk("R9", "exit request code", int'(arb_cmd), C_SELFX);
    grant_measure("R9/R10", C_SELFX, 9, interval_of(2), 9'd2);
    grant_measure("R2 after exit", C_REF, 3, interval_of(2), 9'd2);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_recovery();
    t_rc_change();
    t_blocked();
    t_enter();
    t_asleep();
    t_exit();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule